// File: doc/BRIEF.md
# Converter Start and Serial Readout Controller

This controller sits on the host side of an 18-bit successive-approximation converter that shares one line for two jobs: starting a conversion and selecting the chip for readout. When the controller gets a single start request, it runs one full measurement and then returns to idle. It drives the shared line high, which starts the conversion. It keeps the line high for a fixed number of system clocks that covers the converter's longest conversion time, so the converter never signals busy. It then drops the line to select the chip and runs a divided serial clock. It collects the 18 returned bits, most significant first.

The converter puts its top bit on the data line as soon as select falls, before any clock edge. Each falling serial-clock edge then moves the data line to the next bit. For this reason the controller samples on every rising serial-clock edge. The first rising edge captures the top bit, and the 18th captures the last. After the last falling edge, the controller raises the shared line. In the same cycle it strobes the assembled word for one clock, and the line drops again on the following clock. The conversion wait and the serial-clock half period are parameters counted in system clocks. Reset is synchronous.

Top module: `conv_readout`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, the next cycle shows `cnvOut` = 0, `sckOut` = 0 and `dataValid` = 0. After `rst` is released the block is idle and starts nothing without a start request.
- R2: If `startReq` is high in idle, `cnvOut` goes high at the next edge and stays high for exactly `CONV_CYCLES` clock cycles before falling.
- R3: `sckOut` is low in every cycle in which `cnvOut` is high.
- R4: While `cnvOut` is low during a readout, `sckOut` makes exactly `DATA_BITS` pulses. Each pulse has `SCK_HALF` low cycles followed by `SCK_HALF` high cycles, starting with the low phase right after `cnvOut` falls.
- R5: `sdoIn` is sampled at each edge where `sckOut` rises. The first sample becomes bit `DATA_BITS-1` of `dataWord` and the last becomes bit 0, so a converter that presents its top bit at select-fall and shifts on falling serial-clock edges is read exactly.
- R6: In the cycle after the last serial-clock falling edge, `cnvOut` rises and `dataValid` is high for exactly one cycle, with `dataWord` holding the captured word.
- R7: In the cycle after `dataValid`, `cnvOut` is low and the block is idle again.
- R8: A `startReq` seen while a conversion or readout is in progress has no effect. The running word completes unchanged, and no new conversion follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request one conversion and readout; acted on only in idle |
| sdoIn | input | 1 | Serial data from the converter |
| cnvOut | output | 1 | Shared convert-start and chip-select line |
| sckOut | output | 1 | Serial clock to the converter |
| dataWord | output | DATA_BITS | Assembled result, valid when `dataValid` is high |
| dataValid | output | 1 | One-cycle strobe marking a finished word |

## Verification
A bench-side converter model shifts a programmed word out on falling serial-clock edges and presents its top bit at select-fall. The model is loaded with alternating patterns, all-ones, all-zeros, single-bit words at either end and an irregular mix. These patterns separate a correct capture from an off-by-one sample point, a reversed bit order, a lost top bit and a stuck shift input. Some of the runs also hold the start request high throughout the busy period, to show that it is ignored. A reset issued in the middle of the serial phase confirms that the outputs return to their idle values and that a clean word is captured afterwards.

// File: rtl/conv_readout_pkg.sv
package conv_readout_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_SHIFT,
    ST_DONE
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // new word begins
    logic sample;  // take sdoIn on this edge
  } dpStrobe_t;

endpackage

// File: rtl/conv_readout_ctrl.sv
module conv_readout_ctrl
  import conv_readout_pkg::*;
#(
  parameter int DATA_BITS   = 18,
  parameter int CONV_CYCLES = 40,
  parameter int SCK_HALF    = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      startReq,
  output dpStrobe_t strobe,
  output logic      cnvOut,
  output logic      sckOut,
  output logic      dataValid
);

  localparam int CONV_W = $clog2(CONV_CYCLES + 1);
  localparam int DIV_W  = $clog2(2 * SCK_HALF + 1);
  localparam int BIT_W  = $clog2(DATA_BITS + 1);

  ctlState_t        state;
  logic [CONV_W-1:0] convCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              cnvQ, sckQ, validQ;

  logic convLast, riseNow, fallNow, bitLast;

  always_comb begin
    convLast = (state == ST_CONV) && (convCnt == CONV_W'(CONV_CYCLES - 1));
    riseNow  = (state == ST_SHIFT) && (divCnt == DIV_W'(SCK_HALF - 1));
    fallNow  = (state == ST_SHIFT) && (divCnt == DIV_W'(2 * SCK_HALF - 1));
    bitLast  = (bitCnt == BIT_W'(DATA_BITS - 1));
    strobe.clear  = (state == ST_IDLE) && startReq;
    strobe.sample = riseNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      convCnt <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      cnvQ    <= 1'b0;
      sckQ    <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      validQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_CONV;
            convCnt <= '0;
            cnvQ    <= 1'b1;
          end
        end
        ST_CONV: begin
          if (convLast) begin
            state  <= ST_SHIFT;
            cnvQ   <= 1'b0;
            divCnt <= '0;
            bitCnt <= '0;
          end else begin
            convCnt <= convCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (riseNow) sckQ <= 1'b1;
          if (fallNow) begin
            sckQ   <= 1'b0;
            divCnt <= '0;
            if (bitLast) begin
              state  <= ST_DONE;
              cnvQ   <= 1'b1;
              validQ <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
          cnvQ  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cnvOut    = cnvQ;
  assign sckOut    = sckQ;
  assign dataValid = validQ;

endmodule

// File: rtl/conv_readout_dp.sv
module conv_readout_dp
  import conv_readout_pkg::*;
#(
  parameter int DATA_BITS = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpStrobe_t            strobe,
  input  logic                 sdoIn,
  output logic [DATA_BITS-1:0] dataWord
);

  logic [DATA_BITS-1:0] shiftReg;

  // First sample lands in the top bit after DATA_BITS shifts
  always_ff @(posedge clk) begin
    if (rst || strobe.clear) shiftReg <= '0;
    else if (strobe.sample)  shiftReg <= {shiftReg[DATA_BITS-2:0], sdoIn};
  end

  assign dataWord = shiftReg;

endmodule

// File: rtl/conv_readout.sv
module conv_readout
  import conv_readout_pkg::*;
#(
  parameter int DATA_BITS   = 18,
  parameter int CONV_CYCLES = 40,
  parameter int SCK_HALF    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 startReq,
  input  logic                 sdoIn,
  output logic                 cnvOut,
  output logic                 sckOut,
  output logic [DATA_BITS-1:0] dataWord,
  output logic                 dataValid
);

  dpStrobe_t strobe;

  conv_readout_ctrl #(
    .DATA_BITS  (DATA_BITS),
    .CONV_CYCLES(CONV_CYCLES),
    .SCK_HALF   (SCK_HALF)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .strobe   (strobe),
    .cnvOut   (cnvOut),
    .sckOut   (sckOut),
    .dataValid(dataValid)
  );

  conv_readout_dp #(
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .sdoIn   (sdoIn),
    .dataWord(dataWord)
  );

endmodule

// File: rtl/conv_readout_chk.sv
module conv_readout_chk #(
  parameter int CONV_CYCLES = 40
) (
  input logic clk,
  input logic rst,
  input logic cnvOut,
  input logic sckOut,
  input logic dataValid
);

  logic [31:0] runLen;

  always_ff @(posedge clk) begin
    if (rst)         runLen <= '0;
    else if (cnvOut) runLen <= runLen + 1;
    else             runLen <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!cnvOut && !sckOut && !dataValid));

  // A high run longer than the one-cycle done pulse is a conversion wait
  p_conv_width_r2: assert property (@(posedge clk) disable iff (rst)
    (!cnvOut && runLen > 32'd1) |-> (runLen == 32'(CONV_CYCLES)));

  p_sck_low_cnv_r3: assert property (@(posedge clk) disable iff (rst)
    cnvOut |-> !sckOut);

  p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> $rose(cnvOut));

  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid);

  p_idle_after_r7: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !cnvOut);

endmodule

bind conv_readout conv_readout_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnvOut   (cnvOut),
  .sckOut   (sckOut),
  .dataValid(dataValid)
);

// File: tb/tb_conv_readout.sv
module tb_conv_readout;

  localparam int CLK_PERIOD  = 10;
  localparam int DATA_BITS   = 18;
  localparam int CONV_CYCLES = 12;
  localparam int SCK_HALF    = 2;
  localparam int NVEC        = 8;

  localparam logic [DATA_BITS-1:0] VEC_WORD [NVEC] = '{
    18'h2AAAA, 18'h15555, 18'h3FFFF, 18'h00000,
    18'h20000, 18'h00001, 18'h20001, 18'h1E0F3
  };
  localparam bit VEC_INJ [NVEC] = '{0, 1, 0, 1, 0, 0, 1, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic sdoIn;
  logic cnvOut, sckOut, dataValid;
  logic [DATA_BITS-1:0] dataWord;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // converter model
  logic [DATA_BITS-1:0] adcWord = '0;
  int bitIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_readout #(
    .DATA_BITS  (DATA_BITS),
    .CONV_CYCLES(CONV_CYCLES),
    .SCK_HALF   (SCK_HALF)
  ) dut (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .sdoIn    (sdoIn),
    .cnvOut   (cnvOut),
    .sckOut   (sckOut),
    .dataWord (dataWord),
    .dataValid(dataValid)
  );

  always @(posedge cnvOut) bitIdx = 0;
  always @(negedge sckOut) if (!cnvOut) bitIdx = bitIdx + 1;
  assign sdoIn = (!cnvOut && bitIdx < DATA_BITS) ? adcWord[DATA_BITS-1-bitIdx] : 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic runOne(input logic [DATA_BITS-1:0] w, input bit inject);
    int hi = 0, sckBad = 0, rises = 0, highCyc = 0, guard = 0;
    logic prevSck = 1'b0;
    adcWord = w;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = inject;
    while (cnvOut && hi < 1000) begin
      hi++;
      if (sckOut) sckBad++;
      @(negedge clk);
    end
    chk("R2", "conversion high cycles", hi, CONV_CYCLES);
    chk("R3", "sck high while cnv high", sckBad, 0);
    while (!cnvOut && guard < 5000) begin
      if (sckOut) highCyc++;
      if (sckOut && !prevSck) rises++;
      prevSck = sckOut;
      guard++;
      @(negedge clk);
    end
    startReq = 1'b0;
    chk("R4", "sck pulses", rises, DATA_BITS);
    chk("R4", "sck high cycles", highCyc, DATA_BITS * SCK_HALF);
    chk("R4", "readout cycles", guard, 2 * DATA_BITS * SCK_HALF);
    chk("R6", "valid with cnv rise", dataValid, 1);
    chk("R5", "captured word", dataWord, w);
    @(negedge clk);
    chk("R6", "valid single cycle", dataValid, 0);
    chk("R7", "cnv low after valid", cnvOut, 0);
    if (inject) begin
      int extra = 0;
      for (int k = 0; k < 3 * CONV_CYCLES; k++) begin
        @(negedge clk);
        if (cnvOut) extra++;
      end
      chk("R8", "no conversion from busy start", extra, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "cnv in reset", cnvOut, 0);
    chk("R1", "sck in reset", sckOut, 0);
    chk("R1", "valid in reset", dataValid, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1", "idle without start", cnvOut, 0);

    for (int v = 0; v < NVEC; v++) runOne(VEC_WORD[v], VEC_INJ[v]);

    // reset in the middle of the serial phase
    adcWord = 18'h3C3C3;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    while (cnvOut) @(negedge clk);
    repeat (3 * 2 * SCK_HALF + SCK_HALF) @(negedge clk);
    chk("R4", "sck running before mid reset", sckOut, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "cnv after mid reset", cnvOut, 0);
    chk("R1", "sck after mid reset", sckOut, 0);
    chk("R1", "valid after mid reset", dataValid, 0);
    @(negedge clk) rst = 1'b0;
    begin
      int stray = 0;
      for (int k = 0; k < 4 * DATA_BITS * SCK_HALF; k++) begin
        @(negedge clk);
        if (cnvOut || sckOut || dataValid) stray++;
      end
      chk("R1", "quiet after reset release", stray, 0);
    end
    runOne(18'h0F0F5, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule